// File: doc/BRIEF.md
# Successive-Approximation ADC Control Block

This block sits between a simple register bus and the analog half of a multi-channel successive-approximation converter. Software programs a power-up delay, then writes a control word that switches the converter on, picks one of up to eight inputs and optionally enables the interrupt. Turning the power bit on is the start command. The block waits the programmed number of converter clock periods, takes one sample period, then resolves the result one bit per converter clock, most significant bit first, by presenting trial codes to the DAC and reading the external comparator.

When the last bit is resolved, the result is stored right-aligned in the data register and the busy flag drops. On the same edge the interrupt status bit is set. The interrupt line is high while that status bit and the enable bit are both set. Writing a control word with the power bit clear switches the converter off, aborts any conversion in flight and clears the interrupt. Converter clock periods are marked by an enable input that is high for one system clock per period, so the block runs on the bus clock alone.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `adc_pwr` is low.
- R2: The register index is `paddr[3:2]`: 0 is data, 1 is status, 2 is control and 3 is delay. In the control word, bits 2:0 are the channel, bit 3 is power, bit 5 is interrupt enable and bit 6 is the read-only interrupt status. `adc_pwr` follows bit 3.
- R3: A conversion starts only on the write that changes power from 0 to 1. Rewriting control with power already 1 starts nothing. `adc_ch` holds the channel captured at the start.
- R4: Busy (status bit 0) rises on the starting write edge. It is followed by exactly D converter-clock periods with neither sample nor trial code, where D is the 6-bit delay register (bits 5:0).
- R5: After the delay, `adc_sample` is high for one converter clock. RES_W trial cycles follow, starting at code 1<<(RES_W-1). Each trial code is the bits kept so far OR the bit under test, and the bit is kept when `cmp_in` is 1. `dac_code` is 0 outside the trial cycles.
- R6: With one tick per clock, busy stays high for D+1+RES_W cycles after the start edge. It falls on the edge that loads the data register. The result is right-aligned with the upper bits reading 0, and the interrupt status is set on that edge.
- R7: `irq` is high exactly when the interrupt status and the interrupt enable are both 1.
- R8: Writing control with power 0 aborts the conversion, clears busy and the interrupt status on that edge, and leaves the data register unchanged.
- R9: Writes to the data and status registers have no effect.
- R10: The delay, the sample and the trial steps advance only in cycles where `conv_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase; a write takes effect on the edge where psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address; bits 3:2 index the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data of the addressed register (combinational) |
| conv_tick | input | 1 | One-cycle marker of each converter clock period |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |
| adc_pwr | output | 1 | Converter power enable |
| adc_ch | output | 3 | Channel captured at the start of conversion |
| adc_sample | output | 1 | Sample phase of the converter |
| dac_code | output | RES_W | Trial code for the DAC |
| irq | output | 1 | Interrupt request |

## Verification
A stale delay count or a wrong sequencer state shows up within one converter clock. It appears as a sample pulse in the wrong cycle or a trial code that is not the expected power of two, so the bench counts delay, sample and trial cycles after each start. A wrong kept-bit register corrupts the next trial code and then the stored result. This is exposed by sweeping comparator thresholds that force both decisions at every bit. Stuck interrupt status or a missed abort appears at once on `irq` and in the busy bit after a power-down write.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int REG_IDX_W = 2;
    localparam int CH_W      = 3;

    localparam logic [REG_IDX_W-1:0] IDX_DATA = 2'd0;
    localparam logic [REG_IDX_W-1:0] IDX_STAT = 2'd1;
    localparam logic [REG_IDX_W-1:0] IDX_CTRL = 2'd2;
    localparam logic [REG_IDX_W-1:0] IDX_DLY  = 2'd3;

    localparam int BIT_PWR = 3;
    localparam int BIT_IE  = 5;
    localparam int BIT_STS = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SAMPLE,
        SEQ_CONV
    } seq_state_t;

    typedef struct packed {
        logic            irq_en;
        logic            pwr;
        logic [CH_W-1:0] ch;
    } ctrl_t;

    function automatic logic [7:0] pack_ctrl(ctrl_t c, logic sts);
        logic [7:0] w;
        w = '0;
        w[CH_W-1:0] = c.ch;
        w[BIT_PWR]  = c.pwr;
        w[BIT_IE]   = c.irq_en;
        w[BIT_STS]  = sts;
        return w;
    endfunction

endpackage

// File: rtl/sadc_delay.sv
module sadc_delay #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    output logic             active,
    output logic             go
);

    logic [DLY_W-1:0] cnt;

    always_comb begin
        go = !abort && ((start && dly == '0) ||
                        (active && tick && cnt == DLY_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= (dly != '0);
            cnt    <= dly;
        end else if (active && tick) begin
            cnt <= cnt - DLY_W'(1);
            if (cnt == DLY_W'(1)) begin
                active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             abort,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic             sampling,
    output logic [RES_W-1:0] dac_code,
    output logic             done,
    output logic [RES_W-1:0] result
);

    localparam int IDX_W = $clog2(RES_W);

    seq_state_t       state;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] kept;
    logic [RES_W-1:0] trial;
    logic [RES_W-1:0] kept_next;

    always_comb begin
        trial     = kept | (RES_W'(1) << bit_idx);
        kept_next = cmp_in ? trial : kept;
        dac_code  = (state == SEQ_CONV) ? trial : '0;
        sampling  = (state == SEQ_SAMPLE);
        busy      = (state != SEQ_IDLE);
        done      = (state == SEQ_CONV) && tick && (bit_idx == '0);
        result    = kept_next;
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state   <= SEQ_IDLE;
            bit_idx <= '0;
            kept    <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (go) begin
                        state <= SEQ_SAMPLE;
                        kept  <= '0;
                    end
                end
                SEQ_SAMPLE: begin
                    if (tick) begin
                        state   <= SEQ_CONV;
                        bit_idx <= IDX_W'(RES_W - 1);
                    end
                end
                SEQ_CONV: begin
                    if (tick) begin
                        if (bit_idx == '0) begin
                            state <= SEQ_IDLE;
                            kept  <= '0;
                        end else begin
                            kept    <= kept_next;
                            bit_idx <= bit_idx - IDX_W'(1);
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sadc_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int DLY_W  = 6,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              conv_tick,
    input  logic              cmp_in,
    output logic              adc_pwr,
    output logic [CH_W-1:0]   adc_ch,
    output logic              adc_sample,
    output logic [RES_W-1:0]  dac_code,
    output logic              irq
);

    logic [REG_IDX_W-1:0] reg_idx;
    logic                 wr_en;
    logic                 ctrl_wr;
    logic                 dly_wr;
    ctrl_t                ctrl_q;
    ctrl_t                ctrl_new;
    logic [DLY_W-1:0]     dly_q;
    logic [RES_W-1:0]     data_q;
    logic                 irq_sts_q;
    logic [CH_W-1:0]      ch_q;
    logic                 start;
    logic                 abort;
    logic                 dly_active;
    logic                 dly_go;
    logic                 seq_busy;
    logic                 seq_done;
    logic                 done_ok;
    logic [RES_W-1:0]     seq_result;
    logic                 busy;
    logic                 unused_bits;

    assign unused_bits = ^{paddr[1:0], paddr[ADDR_W-1:REG_IDX_W+2], pwdata[DATA_W-1:6]};

    always_comb begin
        reg_idx         = paddr[REG_IDX_W+1:2];
        wr_en           = psel && penable && pwrite;
        ctrl_wr         = wr_en && (reg_idx == IDX_CTRL);
        dly_wr          = wr_en && (reg_idx == IDX_DLY);
        ctrl_new.ch     = pwdata[CH_W-1:0];
        ctrl_new.pwr    = pwdata[BIT_PWR];
        ctrl_new.irq_en = pwdata[BIT_IE];
        start           = ctrl_wr && ctrl_new.pwr && !ctrl_q.pwr;
        abort           = ctrl_wr && !ctrl_new.pwr;
        done_ok         = seq_done && !abort;
        busy            = dly_active || seq_busy;
    end

    sadc_delay #(.DLY_W(DLY_W)) delay_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .abort  (abort),
        .tick   (conv_tick),
        .dly    (dly_q),
        .active (dly_active),
        .go     (dly_go)
    );

    sadc_seq #(.RES_W(RES_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .go       (dly_go),
        .abort    (abort),
        .tick     (conv_tick),
        .cmp_in   (cmp_in),
        .busy     (seq_busy),
        .sampling (adc_sample),
        .dac_code (dac_code),
        .done     (seq_done),
        .result   (seq_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            dly_q     <= '0;
            data_q    <= '0;
            irq_sts_q <= 1'b0;
            ch_q      <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_new;
            end
            if (dly_wr) begin
                dly_q <= pwdata[DLY_W-1:0];
            end
            if (start) begin
                ch_q <= ctrl_new.ch;
            end
            if (done_ok) begin
                data_q <= seq_result;
            end
            if (abort) begin
                irq_sts_q <= 1'b0;
            end else if (done_ok) begin
                irq_sts_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (reg_idx)
            IDX_DATA: prdata = DATA_W'(data_q);
            IDX_STAT: prdata = DATA_W'(busy);
            IDX_CTRL: prdata = DATA_W'(pack_ctrl(ctrl_q, irq_sts_q));
            default:  prdata = DATA_W'(dly_q);
        endcase
    end

    assign adc_pwr = ctrl_q.pwr;
    assign adc_ch  = ch_q;
    assign irq     = irq_sts_q && ctrl_q.irq_en;

endmodule

// File: rtl/sadc_chk.sv
module sadc_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             sts,
    input logic             irq,
    input logic             adc_pwr,
    input logic [2:0]       adc_ch,
    input logic             adc_sample,
    input logic [RES_W-1:0] dac_code
);

    // R6: a conversion that ends while powered leaves the status bit set
    a_r6_end_sets_status: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && adc_pwr) |-> sts);

    // R8: no activity and no interrupt while the converter is off
    a_r8_off_is_quiet: assert property (@(posedge clk) disable iff (rst)
        !adc_pwr |-> (!busy && !irq));

    // R3: channel held for the whole conversion
    a_r3_channel_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(adc_ch));

    // R5: no trial code outside a conversion
    a_r5_dac_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_code == '0));

    // R5: sampling and trial phases never overlap
    a_r5_sample_no_trial: assert property (@(posedge clk) disable iff (rst)
        adc_sample |-> (dac_code == '0 && busy));

endmodule

bind sar_adc_ctrl sadc_chk #(.RES_W(RES_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .sts        (irq_sts_q),
    .irq        (irq),
    .adc_pwr    (adc_pwr),
    .adc_ch     (adc_ch),
    .adc_sample (adc_sample),
    .dac_code   (dac_code)
);

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;

    localparam int RES_W = 12;
    localparam int NVEC  = 8;
    localparam logic [3:0] A_DATA = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_CTRL = 4'h8;
    localparam logic [3:0] A_DLY  = 4'hC;

    // {channel, irq enable, delay, analog level}
    localparam logic [21:0] VEC [0:NVEC-1] = '{
        {3'd0, 1'b1, 6'd0,  12'h000},
        {3'd1, 1'b1, 6'd1,  12'hFFF},
        {3'd2, 1'b0, 6'd8,  12'h800},
        {3'd3, 1'b1, 6'd63, 12'h7FF},
        {3'd4, 1'b1, 6'd2,  12'h555},
        {3'd5, 1'b0, 6'd5,  12'hAAA},
        {3'd6, 1'b1, 6'd3,  12'h001},
        {3'd7, 1'b1, 6'd12, 12'h9C3}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             psel = 1'b0;
    logic             penable = 1'b0;
    logic             pwrite = 1'b0;
    logic [3:0]       paddr = '0;
    logic [31:0]      pwdata = '0;
    logic [31:0]      prdata;
    logic             conv_tick = 1'b1;
    logic             cmp_in;
    logic             adc_pwr;
    logic [2:0]       adc_ch;
    logic             adc_sample;
    logic [RES_W-1:0] dac_code;
    logic             irq;
    logic [RES_W-1:0] vin = '0;
    logic             div_mode = 1'b0;

    int nchk  = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    always @(negedge clk) begin
        if (div_mode) conv_tick <= ~conv_tick;
        else          conv_tick <= 1'b1;
    end

    sar_adc_ctrl #(.RES_W(RES_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .conv_tick  (conv_tick),
        .cmp_in     (cmp_in),
        .adc_pwr    (adc_pwr),
        .adc_ch     (adc_ch),
        .adc_sample (adc_sample),
        .dac_code   (dac_code),
        .irq        (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        paddr = a;
        #0.1;
        d = prdata;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R6: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        bus_read(A_DATA, rd); check(rd == 0, "R1 data after reset", rd, 0);
        bus_read(A_STAT, rd); check(rd == 0, "R1 status after reset", rd, 0);
        bus_read(A_CTRL, rd); check(rd == 0, "R1 control after reset", rd, 0);
        bus_read(A_DLY, rd);  check(rd == 0, "R1 delay after reset", rd, 0);
        check(irq == 0 && adc_pwr == 0, "R1 irq/pwr after reset", {irq, adc_pwr}, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  ch;
            logic        ie;
            logic [5:0]  dly;
            int          busy_n, pre_n, samp_n, conv_n;
            logic [11:0] first_code;
            logic [31:0] cw;
            {ch, ie, dly, vin} = VEC[v];
            bus_write(A_CTRL, 32'h0);
            bus_write(A_DLY, 32'(dly));
            cw = 32'(ch) | (32'(1) << 3) | (32'(ie) << 5);
            bus_write(A_CTRL, cw);
            busy_n = 0; pre_n = 0; samp_n = 0; conv_n = 0; first_code = '0;
            for (int k = 0; k < 200; k++) begin
                bus_read(A_STAT, rd);
                if (!rd[0]) break;
                busy_n++;
                if (adc_sample) samp_n++;
                else if (dac_code != 0) begin
                    if (conv_n == 0) first_code = dac_code;
                    conv_n++;
                end else pre_n++;
                @(negedge clk);
            end
            check(pre_n == int'(dly), "R4 delay cycles", pre_n, dly);
            check(samp_n == 1, "R5 sample cycles", samp_n, 1);
            check(conv_n == RES_W, "R5 trial cycles", conv_n, RES_W);
            check(first_code == 12'h800, "R5 first trial code MSB", first_code, 12'h800);
            check(busy_n == int'(dly) + 1 + RES_W, "R6 busy length", busy_n,
                  int'(dly) + 1 + RES_W);
            bus_read(A_DATA, rd); check(rd == 32'(vin), "R6 data result", rd, vin);
            bus_read(A_CTRL, rd);
            check(rd == (cw | 32'h40), "R2 control readback with status", rd, cw | 32'h40);
            check(irq == ie, "R7 irq follows enable", irq, ie);
            check(adc_ch == ch && adc_pwr, "R2 channel and power pins", {adc_pwr, adc_ch},
                  {1'b1, ch});
        end

        // R3: rewrite with power already on starts nothing
        bus_write(A_CTRL, 32'h2A);
        wait_cycles(3);
        bus_read(A_STAT, rd); check(rd[0] == 0, "R3 no restart busy", rd, 0);
        check(adc_ch == 3'd7, "R3 channel latched at start", adc_ch, 7);
        bus_read(A_CTRL, rd); check(rd == 32'h6A, "R3 control rewritten", rd, 32'h6A);
        check(irq == 1, "R7 irq still set", irq, 1);

        // R9: data and status are read-only
        bus_write(A_DATA, 32'hFFFF);
        bus_write(A_STAT, 32'h1);
        bus_read(A_DATA, rd); check(rd == 32'h9C3, "R9 data unchanged", rd, 32'h9C3);
        bus_read(A_STAT, rd); check(rd == 0, "R9 status unchanged", rd, 0);

        // R8: power-down clears status and irq, keeps data
        bus_write(A_CTRL, 32'h0);
        check(irq == 0 && adc_pwr == 0, "R8 irq cleared", {irq, adc_pwr}, 0);
        bus_read(A_CTRL, rd); check(rd == 0, "R8 control cleared", rd, 0);
        vin = 12'h123;
        bus_write(A_DLY, 32'd20);
        bus_write(A_CTRL, 32'h28);
        wait_cycles(5);
        bus_read(A_STAT, rd); check(rd[0] == 1, "R4 busy during delay", rd, 1);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_STAT, rd); check(rd[0] == 0, "R8 abort clears busy", rd, 0);
        wait_cycles(40);
        bus_read(A_DATA, rd); check(rd == 32'h9C3, "R8 data kept after abort", rd, 32'h9C3);
        bus_read(A_CTRL, rd); check(rd == 0, "R8 no status after abort", rd, 0);
        check(irq == 0, "R8 irq low after abort", irq, 0);

        // R10: converter tick every other cycle
        vin = 12'h3A5;
        bus_write(A_DLY, 32'd2);
        div_mode = 1'b1;
        bus_write(A_CTRL, 32'h29);
        begin
            int busy_n = 0;
            for (int k = 0; k < 200; k++) begin
                bus_read(A_STAT, rd);
                if (!rd[0]) break;
                busy_n++;
                @(negedge clk);
            end
            check(busy_n == 29 || busy_n == 30, "R10 busy length at half rate", busy_n, 30);
        end
        div_mode = 1'b0;
        bus_read(A_DATA, rd); check(rd == 32'h3A5, "R10 data at half rate", rd, 32'h3A5);
        check(irq == 1, "R7 irq after half-rate run", irq, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule